// File: doc/BRIEF.md
# UART Transmitter with Line Readback Check

This block serialises one 8-bit character at a time onto a single transmit line. Each character goes out as a low start bit, the data bits least significant first, and a high stop bit. Bit time is not a fixed number of system clocks. It is a programmable number of prescaler ticks, from 6 to 16. The prescaler itself lives outside the block and reaches it as a one-cycle enable.

On a half-duplex link the transmitter and receiver share one wire. The block therefore listens to the receive pin while it sends. The pin passes through a synchroniser, and the block compares it with the bit it is driving at one instant inside every bit. That instant is the tick after the middle sample, which leaves room for loopback delay in the physical layer. Any disagreement raises a sticky error flag. Only a dedicated clear input lowers the flag again, and the character still completes.

Top module: `uart_tx_readback`

## Requirements
- R1: After reset, `tx_pin` is 1 and `busy`, `done` and `bit_err` are 0. Whenever `busy` is 0, `tx_pin` is 1.
- R2: A `tx_start` seen while `busy` is 0 starts a character. At the next clock edge `busy` rises and `tx_pin` goes to 0 (start bit). `tx_data` and the sample setting are captured at that edge, so later changes to them have no effect on this character.
- R3: The ten bits are driven in this order: 0, data bit 0 through data bit 7, then 1. Each bit lasts exactly N prescaler ticks, where a tick is a clock cycle with `presc_tick` high. The line changes at the clock edge of the N-th tick of each bit.
- R4: N equals `samp_per_bit` when that value is between 6 and 16. Values below 6 give N = 6, and values above 16 give N = 16.
- R5: At the clock edge of the final tick of the stop bit, `busy` falls and `done` rises. `done` stays high for exactly one clock.
- R6: A `tx_start` pulse while `busy` is 1 is ignored. The character in flight is unchanged, and no further character follows it.
- R7: Within each bit, ticks are numbered 1 to N. The check happens at tick M+1, where M = floor((N+1)/2). At that edge, the receive level after a two-flop synchroniser is compared with the driven bit, and a difference sets `bit_err` at the same edge. The receive level at every other tick has no effect.
- R8: The comparison is made only when `chk_en` and `half_duplex` are both 1. Otherwise a mismatch never sets `bit_err`.
- R9: The start bit, all data bits and the stop bit are all compared. A mismatch does not shorten or alter the character.
- R10: `bit_err` stays set until a clock with `err_clr` high clears it. A new character does not clear it. If a mismatch and `err_clr` occur in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_tick | input | 1 | One-cycle prescaler enable; one pulse per sample |
| samp_per_bit | input | 5 | Requested samples per bit (clamped to 6..16) |
| chk_en | input | 1 | Enables readback comparison |
| half_duplex | input | 1 | Link is half-duplex; needed for comparison |
| tx_data | input | 8 | Character to send |
| tx_start | input | 1 | Start request, honoured only while idle |
| rx_pin | input | 1 | Receive pin, read back during sending |
| err_clr | input | 1 | Clears the bit-error flag |
| tx_pin | output | 1 | Transmit line, idles high |
| busy | output | 1 | A character is in progress |
| done | output | 1 | One-clock pulse when the stop bit ends |
| bit_err | output | 1 | Sticky readback mismatch flag |

## Verification
Two events can land on the same clock edge: the flag being set by a mismatch at a compare tick, and the flag being cleared by `err_clr`. The bench provokes this by corrupting the looped-back line for exactly one sample interval that ends on a compare tick, and by pulsing `err_clr` in the clock that carries that tick. The flag is judged after the character ends: it must read 1. A separate run pulses the clear on a tick where nothing mismatches, to show that the clear does work while `busy` is high. Glitches one tick before and one tick after the compare point must leave the flag at 0.

// File: rtl/urb_pkg.sv
package urb_pkg;
   // Level of an idle UART line and of the stop bit.
   localparam logic IDLE_LEVEL = 1'b1;
   // Start and stop bits that wrap every character.
   localparam int unsigned FRAME_OVERHEAD = 2;

   // Sample index whose following tick carries the readback comparison.
   function automatic int unsigned mid_sample(input int unsigned n);
      return (n + 1) / 2;
   endfunction
endpackage

// File: rtl/urb_sync.sv
module urb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   import urb_pkg::*;

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] stg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= {STAGES{IDLE_LEVEL}};
            else if (STAGES == 1) stg_q <= din;
            else stg_q <= {stg_q[(STAGES > 1 ? STAGES-2 : 0):0], din};
         end
         assign dout = stg_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/urb_bit_timer.sv
module urb_bit_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] samp_n,
   output logic             bit_end,
   output logic             chk_pt
);
   import urb_pkg::*;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mid;

   // Ticks already seen in this bit; the tick that finds cnt_q == mid is sample mid+1.
   assign mid     = CNT_W'(mid_sample(int'(samp_n)));
   assign bit_end = run & tick & (cnt_q == samp_n - 1'b1);
   assign chk_pt  = run & tick & (cnt_q == mid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run || bit_end)  cnt_q <= '0;
      else if (tick)             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/urb_frame_seq.sv
module urb_frame_seq #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   input  logic              bit_end,
   output logic              busy,
   output logic              done,
   output logic              tx_bit
);
   import urb_pkg::*;

   localparam int FRAME_W = DATA_W + int'(FRAME_OVERHEAD);
   localparam int IDX_W   = $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

   logic [FRAME_W-1:0] sh_q;
   logic [IDX_W-1:0]   idx_q;
   logic               busy_q;
   logic               done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= {FRAME_W{IDLE_LEVEL}};
         idx_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (load) begin
               sh_q   <= {IDLE_LEVEL, data, ~IDLE_LEVEL};
               idx_q  <= '0;
               busy_q <= 1'b1;
            end
         end else if (bit_end) begin
            if (idx_q == LAST_IDX) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               sh_q  <= {IDLE_LEVEL, sh_q[FRAME_W-1:1]};
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign busy   = busy_q;
   assign done   = done_q;
   assign tx_bit = sh_q[0];
endmodule

// File: rtl/uart_tx_readback.sv
module uart_tx_readback #(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 5,
   parameter int MIN_SAMP    = 6,
   parameter int MAX_SAMP    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              presc_tick,
   input  logic [CNT_W-1:0]  samp_per_bit,
   input  logic              chk_en,
   input  logic              half_duplex,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_start,
   input  logic              rx_pin,
   input  logic              err_clr,
   output logic              tx_pin,
   output logic              busy,
   output logic              done,
   output logic              bit_err
);
   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_SAMP);
   localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_SAMP);

   // Elaboration-time parameter checks.
   generate
      if (MIN_SAMP < 4) begin : g_bad_min
         $error("MIN_SAMP must be at least 4 so the compare tick precedes the bit end");
      end
      if (MAX_SAMP < MIN_SAMP) begin : g_bad_range
         $error("MAX_SAMP must not be below MIN_SAMP");
      end
      if (MAX_SAMP >= (1 << CNT_W)) begin : g_bad_cnt
         $error("CNT_W too narrow for MAX_SAMP");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic             accept;
   logic             bit_end;
   logic             chk_pt;
   logic             rx_s;
   logic             tx_bit;
   logic             mismatch;
   logic             err_q;
   logic [CNT_W-1:0] samp_lim;
   logic [CNT_W-1:0] samp_q;

   always_comb begin
      if (samp_per_bit < MIN_V)      samp_lim = MIN_V;
      else if (samp_per_bit > MAX_V) samp_lim = MAX_V;
      else                           samp_lim = samp_per_bit;
   end

   assign accept = tx_start & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      samp_q <= MIN_V;
      else if (accept) samp_q <= samp_lim;
   end

   urb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rx_pin), .dout(rx_s)
   );

   urb_bit_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(presc_tick),
      .samp_n(samp_q), .bit_end(bit_end), .chk_pt(chk_pt)
   );

   urb_frame_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .load(accept), .data(tx_data),
      .bit_end(bit_end), .busy(busy), .done(done), .tx_bit(tx_bit)
   );

   assign mismatch = chk_pt & chk_en & half_duplex & (rx_s != tx_bit);

   // Set dominates clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err_q <= 1'b0;
      else if (mismatch) err_q <= 1'b1;
      else if (err_clr)  err_q <= 1'b0;
   end

   assign tx_pin  = tx_bit;
   assign bit_err = err_q;
endmodule

// File: rtl/urb_chk.sv
module urb_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_start,
   input logic err_clr,
   input logic busy,
   input logic done,
   input logic tx_pin,
   input logic bit_err
);
   // R1
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx_pin);

   // R2
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start && !busy |=> busy && !tx_pin);

   // R5
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_err && !err_clr |=> bit_err);

   // R10
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr && !busy |=> !bit_err);

   // R7
   err_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bit_err) |-> $past(busy));
endmodule

bind uart_tx_readback urb_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .err_clr(err_clr),
   .busy(busy), .done(done), .tx_pin(tx_pin), .bit_err(bit_err)
);

// File: tb/uart_tx_readback_tb_top.sv
module uart_tx_readback_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       presc_tick = 1'b0;
   logic [4:0] samp_per_bit = 5'd16;
   logic       chk_en = 1'b1;
   logic       half_duplex = 1'b1;
   logic [7:0] tx_data = 8'h00;
   logic       tx_start = 1'b0;
   logic       rx_pin;
   logic       err_clr = 1'b0;
   logic       tx_pin, busy, done, bit_err;

   // Line model: 0 loopback, 1 held low, 2 held high, 3 loopback with one-tick glitch
   logic [1:0] line_mode = 2'd0;
   logic       glitch = 1'b0;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   assign rx_pin = (line_mode == 2'd1) ? 1'b0 :
                   (line_mode == 2'd2) ? 1'b1 : (tx_pin ^ glitch);

   uart_tx_readback dut_i (
      .clk(clk), .rst_n(rst_n), .presc_tick(presc_tick), .samp_per_bit(samp_per_bit),
      .chk_en(chk_en), .half_duplex(half_duplex), .tx_data(tx_data), .tx_start(tx_start),
      .rx_pin(rx_pin), .err_clr(err_clr), .tx_pin(tx_pin), .busy(busy), .done(done),
      .bit_err(bit_err)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         tests = tests + 1;
         fails = fails + 1;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   typedef struct packed {
      logic [4:0] cfg;
      logic [4:0] n;
      logic [7:0] data;
      logic [1:0] mode;
      logic [7:0] gl;
      logic       ce;
      logic       hd;
      logic       exp_e;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{5'd16, 5'd16, 8'hA5, 2'd0, 8'd0,   1'b1, 1'b1, 1'b0, 4'd3},  // R3 clean loopback
      '{5'd6,  5'd6,  8'h3C, 2'd0, 8'd0,   1'b1, 1'b1, 1'b0, 4'd3},  // R3 shortest bit
      '{5'd3,  5'd6,  8'h81, 2'd0, 8'd0,   1'b1, 1'b1, 1'b0, 4'd4},  // R4 clamp low
      '{5'd20, 5'd16, 8'h5A, 2'd0, 8'd0,   1'b1, 1'b1, 1'b0, 4'd4},  // R4 clamp high
      '{5'd11, 5'd11, 8'h00, 2'd1, 8'd0,   1'b1, 1'b1, 1'b1, 4'd9},  // R9 stop bit caught
      '{5'd9,  5'd9,  8'hFF, 2'd2, 8'd0,   1'b1, 1'b1, 1'b1, 4'd9},  // R9 start bit caught
      '{5'd8,  5'd8,  8'h6B, 2'd3, 8'd12,  1'b1, 1'b1, 1'b1, 4'd7},  // R7 glitch on compare tick
      '{5'd8,  5'd8,  8'h6B, 2'd3, 8'd11,  1'b1, 1'b1, 1'b0, 4'd7},  // R7 glitch one tick early
      '{5'd8,  5'd8,  8'h6B, 2'd3, 8'd13,  1'b1, 1'b1, 1'b0, 4'd7},  // R7 glitch one tick late
      '{5'd7,  5'd7,  8'hC4, 2'd3, 8'd32,  1'b1, 1'b1, 1'b1, 4'd7},  // R7 odd N
      '{5'd16, 5'd16, 8'h00, 2'd1, 8'd0,   1'b0, 1'b1, 1'b0, 4'd8},  // R8 check disabled
      '{5'd16, 5'd16, 8'h00, 2'd1, 8'd0,   1'b1, 1'b0, 1'b0, 4'd8},  // R8 full duplex
      '{5'd15, 5'd15, 8'h3E, 2'd3, 8'd143, 1'b1, 1'b1, 1'b1, 4'd9},  // R9 stop-bit compare point
      '{5'd6,  5'd6,  8'h99, 2'd3, 8'd3,   1'b1, 1'b1, 1'b1, 4'd9}   // R9 start-bit compare point
   };

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests = tests + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_frame(input int cfg, input int n, input logic [7:0] d,
                            input int mode, input int gl, input logic ce,
                            input logic hd, input bit pre_clr, input int clr_tick,
                            input int ign_tick, input logic exp_e, input string req);
      int   errs = 0;
      int   first_j = -1;
      logic first_act = 1'b0;
      logic first_exp = 1'b0;
      @(negedge clk);
      if (pre_clr) begin
         err_clr = 1'b1;
         @(negedge clk);
         err_clr = 1'b0;
      end
      chk_en       = ce;
      half_duplex  = hd;
      samp_per_bit = 5'(cfg);
      line_mode    = (mode == 3) ? 2'd0 : 2'(mode);
      tx_data      = d;
      tx_start     = 1'b1;
      @(negedge clk);
      tx_start     = 1'b0;
      tx_data      = ~d;            // R2 captured data must not follow this
      samp_per_bit = 5'(31 - cfg);  // R2 captured setting must not follow this
      for (int j = 0; j < 10 * n; j++) begin
         int   b = j / n;
         logic eb = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : d[b-1];
         if (tx_pin !== eb || busy !== 1'b1) begin
            if (errs == 0) begin
               first_j = j; first_act = tx_pin; first_exp = eb;
            end
            errs++;
         end
         glitch = (mode == 3) && (j == gl);
         if (j == ign_tick) begin
            tx_start = 1'b1;
            tx_data  = 8'h00;
         end
         @(negedge clk);
         tx_start = 1'b0;
         @(negedge clk);
         @(negedge clk);
         presc_tick = 1'b1;
         err_clr    = (j == clr_tick);
         @(negedge clk);
         presc_tick = 1'b0;
         err_clr    = 1'b0;
         glitch     = 1'b0;
      end
      if (errs != 0)
         $display("  first bit mismatch at tick %0d: got %0b expected %0b", first_j, first_act, first_exp);
      check(errs == 0, "R3", $sformatf("%s serialization N=%0d", req, n), errs, 0);
      check(done === 1'b1 && busy === 1'b0 && tx_pin === 1'b1, "R5", "done/busy at frame end",
            {done, busy, tx_pin}, 3'b101);
      @(negedge clk);
      check(done === 1'b0, "R5", "done width", done, 0);
      check(bit_err === exp_e, req, "bit_err after frame", bit_err, exp_e);
      line_mode    = 2'd0;
      chk_en       = 1'b1;
      half_duplex  = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(tx_pin === 1'b1 && busy === 1'b0 && done === 1'b0 && bit_err === 1'b0,
            "R1", "outputs in reset", {tx_pin, busy, done, bit_err}, 4'b1000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(tx_pin === 1'b1 && busy === 1'b0 && done === 1'b0 && bit_err === 1'b0,
            "R1", "outputs after reset", {tx_pin, busy, done, bit_err}, 4'b1000);

      for (int i = 0; i < NV; i++) begin
         vec_t v = VECS[i];
         run_frame(int'(v.cfg), int'(v.n), v.data, int'(v.mode), int'(v.gl), v.ce, v.hd,
                   1'b1, -1, -1, v.exp_e, $sformatf("R%0d", v.req));
      end

      // R6 start during a character is ignored
      run_frame(6, 6, 8'h96, 0, 0, 1'b1, 1'b1, 1'b1, -1, 20, 1'b0, "R6");
      repeat (8) @(negedge clk);
      check(busy === 1'b0 && tx_pin === 1'b1, "R6", "no second character", {busy, tx_pin}, 2'b01);

      // R10 flag survives the next character, then clears
      run_frame(8, 8, 8'h6B, 3, 12, 1'b1, 1'b1, 1'b1, -1, -1, 1'b1, "R10");
      run_frame(8, 8, 8'h2D, 0, 0, 1'b1, 1'b1, 1'b0, -1, -1, 1'b1, "R10");
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      check(bit_err === 1'b0, "R10", "clear while idle", bit_err, 0);

      // R10 mismatch and clear on the same edge: set wins
      run_frame(8, 8, 8'h6B, 3, 12, 1'b1, 1'b1, 1'b1, 12, -1, 1'b1, "R10");
      // R10 clear during a character with no mismatch
      run_frame(6, 6, 8'h47, 0, 0, 1'b1, 1'b1, 1'b0, 2, -1, 1'b0, "R10");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule